// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Partner-Ready Gating

This block turns characters written into a one-entry holding register into asynchronous serial frames on a single output line. Each frame has a low start bit, then 5 to 9 data bits with the least significant bit first. An even or odd parity bit may follow the data, and one or two high stop bits close the frame. The bit time comes from a two-stage divider: a programmable prescaler produces sample ticks, and 8 or 16 of those ticks make one bit.

The holding register is copied into the serialiser on the same clock edge that the start bit goes out. The buffer-empty flag therefore rises at once and asks for the next character. A character that is waiting when the last stop bit ends starts the next frame with no idle gap. A separate completion flag reports that the line has gone quiet with nothing left to send. When flow control is switched on, a partner-ready input is looked at only between frames. A frame in progress always finishes, and no new frame starts while the partner is not ready. Clearing the transmit enable parks the line high at once.

Top module: `ser_tx_top`

## Requirements
- R1: After reset, txLine is high, bufEmpty is 1 and txDone is 1.
- R2: A frame starts with one low bit, followed by data bits sent LSB first. The number of data bits is wordLen when wordLen is 5 to 9. Any other wordLen code gives 8 data bits. The line idles high.
- R3: parityMode 2'b01 adds an even parity bit and 2'b10 adds an odd parity bit, each placed right after the last data bit. Codes 2'b00 and 2'b11 add no parity bit.
- R4: twoStop = 0 ends each frame with one high stop bit, and twoStop = 1 ends it with two.
- R5: Every bit lasts divisor × N clock cycles, where N is 16 when overSel = 0 and 8 when overSel = 1. A divisor of 0 acts as 1.
- R6: A wrStb pulse loads wrData into the holding register and clears bufEmpty and txDone from the next cycle. A second write before the frame starts replaces the waiting character. bufEmpty returns to 1 on the same edge that the start bit appears.
- R7: If a character is waiting when the last stop bit ends, its start bit follows on the very next cycle.
- R8: With flowEn = 1, no frame starts while partnerRdy = 0. partnerRdy changing during a frame does not alter that frame. With flowEn = 0, partnerRdy is ignored.
- R9: No frame starts while txEn = 0. If txEn falls during a frame, the line returns high on the next cycle and a waiting character is kept for later.
- R10: txDone is set when the last stop bit ends with the holding register empty. It stays 0 if a character is still waiting at that point.
- R11: Word length, parity, stop count, divisor and oversample choice are captured when a frame starts. Changes during the frame apply only to later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmitter enable |
| flowEn | input | 1 | Enables partner-ready gating |
| partnerRdy | input | 1 | Partner ready to accept a frame (active high) |
| divisor | input | DIV_W | Prescaler count (0 acts as 1) |
| overSel | input | 1 | Ticks per bit: 0 gives 16, 1 gives 8 |
| wordLen | input | 4 | Data bits per frame (5 to 9) |
| parityMode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| twoStop | input | 1 | 1 selects two stop bits |
| wrStb | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Character to send |
| txLine | output | 1 | Serial output |
| bufEmpty | output | 1 | Holding register can accept a character |
| txDone | output | 1 | Line idle with nothing pending |

## Verification
The hardest situation to reach is a frame boundary where a character is already waiting but cannot go. This needs a second write landing inside a running frame, followed by partner-ready being withdrawn before the last stop bit. The bench gets there by writing a second character as soon as bufEmpty rises after the first frame starts, then dropping partnerRdy partway through that frame. At the boundary the line must stay high, txDone must stay low, and the held character must go out once the partner is ready again. Aborting a frame by clearing txEn while a character waits is reached the same way.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam int MAX_WORD = 9;
  localparam int MIN_WORD = 5;
  localparam int DEF_WORD = 8;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + MAX_WORD + 1 + MAX_STOP;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } parity_e;

  typedef enum logic {ST_IDLE, ST_SEND} txState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // copy holding register into serialiser, drive start bit
    logic shift;  // advance to the next bit of the frame
    logic park;   // return the line to idle high
  } txStrobe_t;

  function automatic logic [3:0] effLen(input logic [3:0] code);
    return (code >= 4'(MIN_WORD) && code <= 4'(MAX_WORD)) ? code : 4'(DEF_WORD);
  endfunction

  function automatic logic parityOn(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  function automatic logic [CNT_W-1:0] frameBits(input logic [3:0] code,
                                                 input logic [1:0] mode,
                                                 input logic       twoStop);
    logic [CNT_W-1:0] n;
    n = CNT_W'(1) + CNT_W'(effLen(code))
      + (twoStop ? CNT_W'(2) : CNT_W'(1))
      + (parityOn(mode) ? CNT_W'(1) : CNT_W'(0));
    return n;
  endfunction

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int DIV_W  = 12,
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] divisor,
  input  logic             overSel,
  output logic             bitTick
);

  localparam int OS_W = $clog2(OVS_HI);

  logic [DIV_W-1:0] divLast, preCnt;
  logic [OS_W-1:0]  ovsLast, osCnt;
  logic             preWrap, osWrap;

  assign preWrap = (preCnt == divLast);
  assign osWrap  = (osCnt == ovsLast);
  assign bitTick = run && preWrap && osWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLast <= '0;
      ovsLast <= '0;
      preCnt  <= '0;
      osCnt   <= '0;
    end else if (load) begin
      // settings captured for the whole frame
      divLast <= (divisor == '0) ? '0 : divisor - DIV_W'(1);
      ovsLast <= overSel ? OS_W'(OVS_LO - 1) : OS_W'(OVS_HI - 1);
      preCnt  <= '0;
      osCnt   <= '0;
    end else if (run) begin
      if (preWrap) begin
        preCnt <= '0;
        osCnt  <= osWrap ? '0 : osCnt + OS_W'(1);
      end else begin
        preCnt <= preCnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEn,
  input  logic      flowEn,
  input  logic      partnerRdy,
  input  logic      wrStb,
  input  logic      bufEmpty,
  input  logic      bitTick,
  input  logic [3:0] wordLen,
  input  logic [1:0] parityMode,
  input  logic      twoStop,
  output txStrobe_t strobe,
  output logic      run,
  output logic      txDone
);

  txState_e         state;
  logic [CNT_W-1:0] bitsLeft;
  logic             ctsOk, startOk, frameEnd, abortNow;

  always_comb begin
    ctsOk    = !flowEn || partnerRdy;
    startOk  = txEn && !bufEmpty && ctsOk;
    abortNow = (state == ST_SEND) && !txEn;
    frameEnd = (state == ST_SEND) && txEn && bitTick && (bitsLeft == CNT_W'(1));
    run      = (state == ST_SEND) && txEn;

    strobe.load  = startOk && ((state == ST_IDLE) || frameEnd);
    strobe.shift = run && bitTick && (bitsLeft != CNT_W'(1));
    strobe.park  = abortNow || (frameEnd && !startOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
    end else begin
      if (strobe.load) begin
        state    <= ST_SEND;
        bitsLeft <= frameBits(wordLen, parityMode, twoStop);
      end else if (strobe.park) begin
        state    <= ST_IDLE;
        bitsLeft <= '0;
      end else if (strobe.shift) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     txDone <= 1'b1;
    else if (wrStb)                txDone <= 1'b0;
    else if (frameEnd && bufEmpty) txDone <= 1'b1;
  end

endmodule

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStb,
  input  logic [MAX_WORD-1:0] wrData,
  input  txStrobe_t           strobe,
  input  logic [3:0]          wordLen,
  input  logic [1:0]          parityMode,
  output logic                bufEmpty,
  output logic                txLine
);

  logic [MAX_WORD-1:0] holdQ;
  logic [FRAME_W-2:0]  shReg;
  logic [FRAME_W-1:0]  frameVec;
  logic [MAX_WORD-1:0] dataMask;
  logic [3:0]          len;
  logic                parBit;

  // mask of the data bits in use for the selected word length
  for (genvar g = 0; g < MAX_WORD; g++) begin : g_mask
    assign dataMask[g] = (g < int'(len));
  end

  always_comb begin
    len      = effLen(wordLen);
    parBit   = ^(holdQ & dataMask);
    if (parityMode == PAR_ODD) parBit = ~parBit;
    frameVec = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < MAX_WORD; i++) begin
      if (dataMask[i]) frameVec[1+i] = holdQ[i];
    end
    if (parityOn(parityMode)) frameVec[len + 4'd1] = parBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ    <= '0;
      bufEmpty <= 1'b1;
    end else begin
      if (wrStb) holdQ <= wrData;
      if (wrStb)            bufEmpty <= 1'b0;
      else if (strobe.load) bufEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '1;
      txLine <= 1'b1;
    end else if (strobe.load) begin
      txLine <= frameVec[0];
      shReg  <= frameVec[FRAME_W-1:1];
    end else if (strobe.park) begin
      txLine <= 1'b1;
      shReg  <= '1;
    end else if (strobe.shift) begin
      txLine <= shReg[0];
      shReg  <= {1'b1, shReg[FRAME_W-2:1]};
    end
  end

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int OVS_HI = 16,
  parameter int OVS_LO = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEn,
  input  logic                flowEn,
  input  logic                partnerRdy,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                overSel,
  input  logic [3:0]          wordLen,
  input  logic [1:0]          parityMode,
  input  logic                twoStop,
  input  logic                wrStb,
  input  logic [MAX_WORD-1:0] wrData,
  output logic                txLine,
  output logic                bufEmpty,
  output logic                txDone
);

  txStrobe_t strobe;
  logic      run, bitTick;

  ser_tx_baud #(.DIV_W(DIV_W), .OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_baud (
    .clk(clk), .rstN(rstN), .run(run), .load(strobe.load),
    .divisor(divisor), .overSel(overSel), .bitTick(bitTick)
  );

  ser_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .flowEn(flowEn),
    .partnerRdy(partnerRdy), .wrStb(wrStb), .bufEmpty(bufEmpty),
    .bitTick(bitTick), .wordLen(wordLen), .parityMode(parityMode),
    .twoStop(twoStop), .strobe(strobe), .run(run), .txDone(txDone)
  );

  ser_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .strobe(strobe), .wordLen(wordLen), .parityMode(parityMode),
    .bufEmpty(bufEmpty), .txLine(txLine)
  );

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txEn,
  input logic flowEn,
  input logic partnerRdy,
  input logic wrStb,
  input logic txLine,
  input logic bufEmpty,
  input logic txDone
);

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> txLine);

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> (!bufEmpty && !txDone));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> !txLine);

  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> $past(!flowEn || partnerRdy));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txLine);

endmodule

bind ser_tx_top ser_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .txEn(txEn), .flowEn(flowEn),
  .partnerRdy(partnerRdy), .wrStb(wrStb), .txLine(txLine),
  .bufEmpty(bufEmpty), .txDone(txDone)
);

// File: tb/tb_ser_tx_top.sv
module tb_ser_tx_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 12;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             txEn = 1'b1, flowEn = 1'b0, partnerRdy = 1'b1;
  logic [DIV_W-1:0] divisor = 12'd1;
  logic             overSel = 1'b1;
  logic [3:0]       wordLen = 4'd8;
  logic [1:0]       parityMode = 2'b00;
  logic             twoStop = 1'b0;
  logic             wrStb = 1'b0;
  logic [8:0]       wrData = '0;
  logic             txLine, bufEmpty, txDone;

  int    nChecks = 0, nFails = 0, cycles = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_tx_top #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .txEn(txEn), .flowEn(flowEn),
    .partnerRdy(partnerRdy), .divisor(divisor), .overSel(overSel),
    .wordLen(wordLen), .parityMode(parityMode), .twoStop(twoStop),
    .wrStb(wrStb), .wrData(wrData), .txLine(txLine),
    .bufEmpty(bufEmpty), .txDone(txDone)
  );

  // behavioural reference model: a queue of line levels per frame
  bit       mBusy = 0, mLine = 1, mEmpty = 1, mDone = 1;
  bit [8:0] mHold = '0;
  bit       bitQ[$];
  int       mCnt = 0, mPer = 1;

  always @(posedge clk) begin
    bit ctsOk, canStart, doStart, setDone, oldEmpty, par;
    int len, ones;
    if (!rstN) begin
      mBusy = 0; mLine = 1; mEmpty = 1; mDone = 1; mHold = '0;
      bitQ.delete(); mCnt = 0;
    end else begin
      ctsOk    = !flowEn || partnerRdy;
      oldEmpty = mEmpty;
      canStart = txEn && !mEmpty && ctsOk;
      doStart  = 0;
      setDone  = 0;
      if (mBusy && !txEn) begin
        mBusy = 0; mLine = 1; bitQ.delete();
      end else if (mBusy) begin
        mCnt++;
        if (mCnt == mPer) begin
          mCnt = 0;
          if (bitQ.size() > 0) mLine = bitQ.pop_front();
          else if (canStart) doStart = 1;
          else begin
            mBusy = 0; mLine = 1;
            if (oldEmpty) setDone = 1;
          end
        end
      end else if (canStart) doStart = 1;

      if (doStart) begin
        len  = (wordLen >= 5 && wordLen <= 9) ? int'(wordLen) : 8;
        ones = 0;
        bitQ.delete();
        bitQ.push_back(1'b0);
        for (int i = 0; i < len; i++) begin
          bitQ.push_back(mHold[i]);
          ones += int'(mHold[i]);
        end
        par = (ones % 2) == 1;
        if (parityMode == 2'b01) bitQ.push_back(par);
        if (parityMode == 2'b10) bitQ.push_back(!par);
        bitQ.push_back(1'b1);
        if (twoStop) bitQ.push_back(1'b1);
        mLine = bitQ.pop_front();
        mBusy = 1;
        mCnt  = 0;
        mPer  = ((divisor == 0) ? 1 : int'(divisor)) * (overSel ? 8 : 16);
      end

      if (wrStb) begin
        mHold = wrData; mEmpty = 0; mDone = 0;
      end else begin
        if (doStart) mEmpty = 1;
        if (setDone) mDone = 1;
      end
    end
  end

  task automatic check1(string what, bit got, bit exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s got %0b expected %0b at cycle %0d", phase, what, got, exp, cycles);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check1("txLine", txLine, mLine);
      check1("bufEmpty", bufEmpty, mEmpty);
      check1("txDone", txDone, mDone);
    end
    if (cycles > WATCHDOG) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic cfg(input int len, input int par, input bit two, input int dv, input bit ovs8);
    @(negedge clk);
    wordLen = 4'(len); parityMode = 2'(par); twoStop = two;
    divisor = DIV_W'(dv); overSel = ovs8;
  endtask

  task automatic wr(input int d);
    @(negedge clk);
    wrStb = 1'b1; wrData = 9'(d);
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic waitDone();
    for (int k = 0; k < 4000 && !txDone; k++) @(negedge clk);
  endtask

  task automatic waitEmpty();
    for (int k = 0; k < 4000 && !bufEmpty; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1 reset txLine", txLine, 1'b1);
    check1("R1 reset bufEmpty", bufEmpty, 1'b1);
    check1("R1 reset txDone", txDone, 1'b1);

    phase = "R2";
    cfg(8, 0, 0, 1, 1); wr(9'h0A5); waitDone();
    cfg(5, 0, 0, 1, 1); wr(9'h1F3); waitDone();
    cfg(9, 0, 0, 1, 1); wr(9'h155); waitDone();
    cfg(12, 0, 0, 1, 1); wr(9'h0C3); waitDone();

    phase = "R3";
    cfg(8, 1, 0, 1, 1); wr(9'h037); waitDone();
    cfg(7, 2, 0, 1, 1); wr(9'h02A); waitDone();
    cfg(8, 3, 0, 1, 1); wr(9'h081); waitDone();

    phase = "R4";
    cfg(8, 0, 1, 1, 1); wr(9'h05A); waitDone();

    phase = "R5";
    cfg(6, 1, 0, 3, 0); wr(9'h02D); waitDone();
    cfg(8, 0, 0, 0, 1); wr(9'h033); waitDone();

    phase = "R7";
    cfg(8, 0, 0, 1, 1);
    wr(9'h011); waitEmpty(); wr(9'h022); waitEmpty(); wr(9'h033); waitDone();

    phase = "R6";
    txEn = 1'b0;
    wr(9'h044); wr(9'h066); idle(20);
    txEn = 1'b1; waitDone();

    phase = "R8";
    flowEn = 1'b1; partnerRdy = 1'b0;
    wr(9'h099); idle(60);
    partnerRdy = 1'b1; idle(20);
    partnerRdy = 1'b0; waitDone();
    flowEn = 1'b0; wr(9'h03C); waitDone();

    phase = "R10";
    flowEn = 1'b1; partnerRdy = 1'b1;
    wr(9'h001); waitEmpty(); wr(9'h002);
    partnerRdy = 1'b0; idle(200);
    partnerRdy = 1'b1; waitDone();
    flowEn = 1'b0;

    phase = "R9";
    wr(9'h07E); idle(30);
    txEn = 1'b0; wr(9'h018); idle(20);
    txEn = 1'b1; waitDone();

    phase = "R11";
    cfg(8, 0, 0, 1, 1); wr(9'h0F0); idle(5);
    cfg(5, 1, 1, 2, 1); waitDone();
    wr(9'h00F); waitDone();
    idle(5);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule